// File: doc/BRIEF.md
# Single-Wire Sensor Bus Line Controller

This block connects a host byte stream to one shared, half-duplex sensor data line that runs at 1200 baud. The line rests low and is active high, the opposite of the usual serial convention, so the block inverts both directions. The bus also needs a start-of-transaction marker: a continuous active level far longer than any character. An ordinary character framer cannot make or recognise it, so the block times this marker on its own, apart from the framer.

To transmit, the host asks for a marker with `brk_req`, then writes 7-bit characters over a valid/ready handshake. The block enables its line driver one bit time ahead of the first activity and drives the marker and a quiet marking gap. It then sends each character with start bit, 7 data bits LSB first, a parity bit and a stop bit. It releases the driver after the last stop bit. To receive, a level timer watches the synchronised line. Once it has seen a full-length marker, it arms a 16x-oversampled character receiver. A wake pulse marks every rising edge of the line, including edges that arrive while the driver is released.

Top module: `sdi_line_ctrl`

## Requirements
- R1: One oversample tick lasts CLK_HZ/(BAUD*OVS) clocks, and every transmitted bit cell lasts exactly OVS ticks.
- R2: A `brk_req` taken while the transmitter is idle produces the bus held high for BRK_TICKS ticks (default 232, about 14.5 bits), followed by the bus held low for MARK_TICKS ticks (default 160, about 8.33 ms) before any character.
- R3: Each character goes onto the bus as a high start bit, then the 7 data bits LSB first, then an even-parity bit (odd when PAR_ODD=1), then a low stop bit. Every bit's bus level is the inverse of its logical value.
- R4: `bus_oe` rises OVS ticks before a marker or a first start bit, with the bus low during that lead. It falls right after the final stop bit. `bus_out` is low whenever `bus_oe` is low.
- R5: A character that is buffered while the previous character or the marker gap is still going out follows right after it, with no lead bit and no gap.
- R6: `brk_req` is ignored unless the transmitter is idle. `tx_busy` is high from an accepted marker request until the line is released.
- R7: The transmitter holds one buffered character. `tx_ready` goes low in the cycle after a handshake and stays low until that character starts being shifted.
- R8: `brk_evt` pulses for one cycle, once, when the synchronised line has stayed high for BRK_TICKS ticks.
- R9: A high level that ends before BRK_TICKS ticks raises no `brk_evt` and leaves the character receiver disabled, so characters before the first marker are not reported.
- R10: After a marker and a return to low, each character with a low stop bit is reported with a one-cycle `rx_valid`. `rx_data` holds the 7 data bits, and `rx_perr` is high when the received parity bit disagrees with the parity mode.
- R11: A start bit that is no longer high at its mid-bit sample (OVS/2 ticks after detection) is dropped, and no character is reported.
- R12: `wake` pulses once for every low-to-high transition of the synchronised line, whatever the state of the driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | DBITS | Character to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmit buffer can take a character |
| brk_req | input | 1 | Request a marker, honoured only when idle |
| tx_busy | output | 1 | Transmit sequence pending or in progress |
| rx_data | output | DBITS | Last received character |
| rx_valid | output | 1 | One-cycle strobe for rx_data/rx_perr |
| rx_perr | output | 1 | Parity mismatch on the reported character |
| brk_evt | output | 1 | One-cycle strobe when a marker is recognised |
| wake | output | 1 | One-cycle strobe on each rising line edge |
| bus_in | input | 1 | Sampled bus level (high = active) |
| bus_out | output | 1 | Bus level to drive |
| bus_oe | output | 1 | Driver enable, low releases the line |

## Verification
The transmitter is exercised with a plain pair of characters, where the second is buffered during the first. It is also exercised with a marker followed by a buffered character, and with a marker request made mid-character. The bench compares the bus level and enable every clock, so these cases separate a lead, marker or gap of wrong length from bit-order or polarity faults, and show whether a late request slips a spurious marker in. The receiver gets a short high pulse and a character before any marker, then a real marker, a start glitch and four characters. Among these are all-ones, all-zeros and a deliberately wrong parity bit, which separate threshold, arming, mid-bit rejection, bit order and parity-check faults.

// File: rtl/sdi_line_pkg.sv
package sdi_line_pkg;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_LEAD,
      TX_BRK,
      TX_MARK,
      TX_FRAME
   } tx_st_t;

   typedef enum logic [2:0] {
      RX_OFF,
      RX_GAP,
      RX_IDLE,
      RX_START,
      RX_BITS
   } rx_st_t;

   // parity bit that makes the total count of ones even (odd = 0) or odd (odd = 1)
   function automatic logic parity_of(input logic [15:0] v, input logic odd);
      return (^v) ^ odd;
   endfunction

endpackage

// File: rtl/sdi_tick_gen.sv
module sdi_tick_gen #(
   parameter int DIV = 10416
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = $clog2(DIV);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (cnt == CW'(DIV - 1))    cnt <= '0;
      else                             cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/sdi_tx.sv
module sdi_tx
   import sdi_line_pkg::*;
#(
   parameter int DBITS      = 7,
   parameter int OVS        = 16,
   parameter int BRK_TICKS  = 232,
   parameter int MARK_TICKS = 160,
   parameter bit PAR_ODD    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [DBITS-1:0] tx_data,
   input  logic             tx_valid,
   output logic             tx_ready,
   input  logic             brk_req,
   output logic             tx_busy,
   output logic             line_out,
   output logic             line_oe
);
   localparam int FRAME = DBITS + 3;
   localparam int MAXT  = (BRK_TICKS > MARK_TICKS) ?
                          ((BRK_TICKS > OVS) ? BRK_TICKS : OVS) :
                          ((MARK_TICKS > OVS) ? MARK_TICKS : OVS);
   localparam int TW    = $clog2(MAXT + 1);
   localparam int BW    = $clog2(FRAME + 1);

   tx_st_t           st;
   logic [TW-1:0]    tcnt;
   logic [BW-1:0]    bcnt;
   logic [FRAME-1:0] sh;
   logic [FRAME-1:0] frame_w;
   logic             buf_vld;
   logic [DBITS-1:0] buf_dat;
   logic             brk_pend;
   logic             to_brk;
   logic             seg_end;

   // serial order from bit 0: start(0), data LSB first, parity, stop(1)
   assign frame_w = {1'b1, parity_of(16'(buf_dat), PAR_ODD), buf_dat, 1'b0};

   always_comb begin
      unique case (st)
         TX_LEAD:  seg_end = (tcnt == TW'(OVS - 1));
         TX_BRK:   seg_end = (tcnt == TW'(BRK_TICKS - 1));
         TX_MARK:  seg_end = (tcnt == TW'(MARK_TICKS - 1));
         TX_FRAME: seg_end = (tcnt == TW'(OVS - 1));
         default:  seg_end = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= TX_IDLE;
         tcnt     <= '0;
         bcnt     <= '0;
         sh       <= '1;
         buf_vld  <= 1'b0;
         buf_dat  <= '0;
         brk_pend <= 1'b0;
         to_brk   <= 1'b0;
      end else begin
         if (tx_valid && !buf_vld) begin
            buf_vld <= 1'b1;
            buf_dat <= tx_data;
         end
         if (brk_req && st == TX_IDLE) brk_pend <= 1'b1;
         if (tick) begin
            if (st == TX_IDLE) begin
               tcnt <= '0;
               if (brk_pend) begin
                  st       <= TX_LEAD;
                  to_brk   <= 1'b1;
                  brk_pend <= 1'b0;
               end else if (buf_vld) begin
                  st      <= TX_LEAD;
                  to_brk  <= 1'b0;
                  sh      <= frame_w;
                  bcnt    <= '0;
                  buf_vld <= 1'b0;
               end
            end else if (!seg_end) begin
               tcnt <= tcnt + 1'b1;
            end else begin
               tcnt <= '0;
               unique case (st)
                  TX_LEAD: st <= to_brk ? TX_BRK : TX_FRAME;
                  TX_BRK:  st <= TX_MARK;
                  TX_MARK: begin
                     if (buf_vld) begin
                        st      <= TX_FRAME;
                        sh      <= frame_w;
                        bcnt    <= '0;
                        buf_vld <= 1'b0;
                     end else begin
                        st <= TX_IDLE;
                     end
                  end
                  TX_FRAME: begin
                     if (bcnt == BW'(FRAME - 1)) begin
                        if (buf_vld) begin
                           sh      <= frame_w;
                           bcnt    <= '0;
                           buf_vld <= 1'b0;
                        end else begin
                           st <= TX_IDLE;
                        end
                     end else begin
                        sh   <= {1'b1, sh[FRAME-1:1]};
                        bcnt <= bcnt + 1'b1;
                     end
                  end
                  default: st <= TX_IDLE;
               endcase
            end
         end
      end
   end

   assign tx_ready = !buf_vld;
   assign tx_busy  = (st != TX_IDLE) || brk_pend;
   assign line_oe  = (st != TX_IDLE);
   assign line_out = (st == TX_BRK) || (st == TX_FRAME && !sh[0]);
endmodule

// File: rtl/sdi_rx.sv
module sdi_rx
   import sdi_line_pkg::*;
#(
   parameter int DBITS     = 7,
   parameter int OVS       = 16,
   parameter int BRK_TICKS = 232,
   parameter int SYNC      = 2,
   parameter bit PAR_ODD   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             bus_in,
   output logic [DBITS-1:0] rx_data,
   output logic             rx_valid,
   output logic             rx_perr,
   output logic             brk_evt,
   output logic             wake
);
   localparam int HW = $clog2(BRK_TICKS + 1);
   localparam int RW = $clog2(OVS);
   localparam int NW = $clog2(DBITS + 2);

   logic [SYNC-1:0] sy;
   logic            lvl;
   logic            lvl_d;
   logic [HW-1:0]   hcnt;
   rx_st_t          rs;
   logic [RW-1:0]   rcnt;
   logic [NW-1:0]   rbit;
   logic [DBITS:0]  rsh;

   for (genvar i = 0; i < SYNC; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      sy[i] <= 1'b0;
         else if (i == 0) sy[i] <= bus_in;
         else             sy[i] <= sy[(i == 0) ? 0 : i - 1];
      end
   end

   assign lvl  = sy[SYNC-1];
   assign wake = lvl && !lvl_d;

   // level timer for the long marker, independent of the character receiver
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d   <= 1'b0;
         hcnt    <= '0;
         brk_evt <= 1'b0;
      end else begin
         lvl_d   <= lvl;
         brk_evt <= 1'b0;
         if (tick) begin
            if (!lvl) begin
               hcnt <= '0;
            end else if (hcnt != HW'(BRK_TICKS)) begin
               hcnt <= hcnt + 1'b1;
               if (hcnt == HW'(BRK_TICKS - 1)) brk_evt <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs       <= RX_OFF;
         rcnt     <= '0;
         rbit     <= '0;
         rsh      <= '0;
         rx_data  <= '0;
         rx_perr  <= 1'b0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (brk_evt) begin
            rs <= RX_GAP;
         end else if (tick) begin
            unique case (rs)
               RX_GAP:  if (!lvl) rs <= RX_IDLE;
               RX_IDLE: if (lvl) begin
                  rs   <= RX_START;
                  rcnt <= '0;
               end
               RX_START: begin
                  if (rcnt == RW'(OVS / 2 - 1)) begin
                     rcnt <= '0;
                     rbit <= '0;
                     rs   <= lvl ? RX_BITS : RX_IDLE;
                  end else begin
                     rcnt <= rcnt + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (rcnt == RW'(OVS - 1)) begin
                     rcnt <= '0;
                     if (rbit == NW'(DBITS + 1)) begin
                        rs <= RX_IDLE;
                        if (!lvl) begin
                           rx_valid <= 1'b1;
                           rx_data  <= rsh[DBITS-1:0];
                           rx_perr  <= (^rsh) != PAR_ODD;
                        end
                     end else begin
                        rsh  <= {!lvl, rsh[DBITS:1]};
                        rbit <= rbit + 1'b1;
                     end
                  end else begin
                     rcnt <= rcnt + 1'b1;
                  end
               end
               default: rs <= RX_OFF;
            endcase
         end
      end
   end
endmodule

// File: rtl/sdi_line_ctrl.sv
module sdi_line_ctrl #(
   parameter int CLK_HZ     = 200_000_000,
   parameter int BAUD       = 1200,
   parameter int OVS        = 16,
   parameter int DBITS      = 7,
   parameter int BRK_TICKS  = 232,
   parameter int MARK_TICKS = 160,
   parameter int SYNC       = 2,
   parameter bit PAR_ODD    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DBITS-1:0] tx_data,
   input  logic             tx_valid,
   output logic             tx_ready,
   input  logic             brk_req,
   output logic             tx_busy,
   output logic [DBITS-1:0] rx_data,
   output logic             rx_valid,
   output logic             rx_perr,
   output logic             brk_evt,
   output logic             wake,
   input  logic             bus_in,
   output logic             bus_out,
   output logic             bus_oe
);
   localparam int DIV = CLK_HZ / (BAUD * OVS);

   if (DIV < 2)
      $error("clock too slow for BAUD*OVS");
   if (OVS < 4 || (OVS % 2) != 0)
      $error("OVS must be even and at least 4");
   if (DBITS < 5 || DBITS > 16)
      $error("DBITS out of range");
   if (BRK_TICKS <= OVS * (DBITS + 2))
      $error("marker must outlast any high run inside a character");
   if (SYNC < 2)
      $error("SYNC needs two stages or more");

   logic tick;

   sdi_tick_gen #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   sdi_tx #(
      .DBITS(DBITS), .OVS(OVS), .BRK_TICKS(BRK_TICKS),
      .MARK_TICKS(MARK_TICKS), .PAR_ODD(PAR_ODD)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .brk_req(brk_req), .tx_busy(tx_busy),
      .line_out(bus_out), .line_oe(bus_oe)
   );

   sdi_rx #(
      .DBITS(DBITS), .OVS(OVS), .BRK_TICKS(BRK_TICKS),
      .SYNC(SYNC), .PAR_ODD(PAR_ODD)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_in(bus_in),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
      .brk_evt(brk_evt), .wake(wake)
   );
endmodule

// File: rtl/sdi_line_ctrl_chk.sv
module sdi_line_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_oe,
   input logic bus_out,
   input logic tx_valid,
   input logic tx_ready,
   input logic brk_evt,
   input logic rx_valid
);
   // R4
   released_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> !bus_out);

   // R4
   lead_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> !bus_out);

   // R4
   release_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_oe) |-> !$past(bus_out));

   // R7
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

   // R8
   brk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt |=> !brk_evt);

   // R10
   rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
endmodule

bind sdi_line_ctrl sdi_line_ctrl_chk chk_i (
   .clk(clk), .rst_n(rst_n), .bus_oe(bus_oe), .bus_out(bus_out),
   .tx_valid(tx_valid), .tx_ready(tx_ready),
   .brk_evt(brk_evt), .rx_valid(rx_valid)
);

// File: tb/sdi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdi_line_ctrl_tb_top;
   localparam int OVS  = 16;
   localparam int BRK  = 232;
   localparam int MARK = 160;
   localparam int D    = 2;          // clocks per oversample tick
   localparam int CLKF = D * 1200 * OVS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] tx_data = '0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic       brk_req = 1'b0;
   logic       tx_busy;
   logic [6:0] rx_data;
   logic       rx_valid;
   logic       rx_perr;
   logic       brk_evt;
   logic       wake;
   logic       bus_in = 1'b0;
   logic       bus_out;
   logic       bus_oe;

   int nvec = 0;
   int nfail = 0;
   int nbrk = 0;
   int nwake = 0;
   int rises = 0;
   logic       ql[$];
   string      qr[$];
   logic [6:0] gd[$];
   logic       gp[$];
   logic [6:0] ed[$];
   logic       ep[$];

   always #2.5 clk = ~clk;

   sdi_line_ctrl #(
      .CLK_HZ(CLKF), .BAUD(1200), .OVS(OVS), .DBITS(7),
      .BRK_TICKS(BRK), .MARK_TICKS(MARK), .SYNC(2), .PAR_ODD(1'b0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .brk_req(brk_req), .tx_busy(tx_busy),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
      .brk_evt(brk_evt), .wake(wake), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      if (brk_evt) nbrk++;
      if (wake) nwake++;
      if (rx_valid) begin
         gd.push_back(rx_data);
         gp.push_back(rx_perr);
      end
   end

   // reference model: expected bus level per clock while the driver is on
   task automatic seg(input logic lvl, input int nt, input string req);
      repeat (nt * D) begin
         ql.push_back(lvl);
         qr.push_back(req);
      end
   endtask

   task automatic frame(input logic [6:0] d, input string req);
      seg(1'b1, OVS, "R1");                     // start bit, bus high
      for (int i = 0; i < 7; i++) seg(!d[i], OVS, req);
      seg(!(^d), OVS, req);                     // even parity, inverted
      seg(1'b0, OVS, req);                      // stop bit, bus low
   endtask

   task automatic play();
      int w;
      logic l;
      string r;
      w = 0;
      @(negedge clk);
      while (bus_oe !== 1'b1 && w < 64 * D) begin
         w++;
         @(negedge clk);
      end
      chk(bus_oe === 1'b1, "R4", int'(bus_oe), 1);
      while (ql.size() > 0) begin
         l = ql.pop_front();
         r = qr.pop_front();
         chk(bus_oe === 1'b1 && bus_out === l, r,
             int'({bus_oe, bus_out}), int'({1'b1, l}));
         @(negedge clk);
      end
      chk(bus_oe === 1'b0 && bus_out === 1'b0, "R4", int'({bus_oe, bus_out}), 0);
   endtask

   task automatic push_byte(input logic [6:0] d);
      @(posedge clk); #1;
      while (!tx_ready) begin @(posedge clk); #1; end
      tx_valid = 1'b1;
      tx_data  = d;
      @(posedge clk); #1;
      tx_valid = 1'b0;
   endtask

   task automatic pulse_brk();
      @(posedge clk); #1;
      brk_req = 1'b1;
      @(posedge clk); #1;
      brk_req = 1'b0;
   endtask

   task automatic drive(input logic l, input int nt);
      @(posedge clk); #1;
      if (l && !bus_in) rises++;
      bus_in = l;
      repeat (nt * D - 1) @(posedge clk);
   endtask

   task automatic send_char(input logic [6:0] d, input bit badpar, input bit expect_it);
      logic p;
      p = (^d) ^ badpar;
      drive(1'b1, OVS);
      for (int i = 0; i < 7; i++) drive(!d[i], OVS);
      drive(!p, OVS);
      drive(1'b0, OVS);
      drive(1'b0, OVS);
      if (expect_it) begin
         ed.push_back(d);
         ep.push_back(badpar);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      int quiet;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // reset state (R4, R6, R7)
      chk(!bus_oe && !bus_out, "R4", int'({bus_oe, bus_out}), 0);
      chk(tx_ready === 1'b1, "R7", int'(tx_ready), 1);
      chk(tx_busy === 1'b0, "R6", int'(tx_busy), 0);
      chk(!rx_valid && !brk_evt, "R8", int'({rx_valid, brk_evt}), 0);

      // two characters, second buffered during the first; marker request mid-frame (R5, R6)
      seg(1'b0, OVS, "R4");
      frame(7'h55, "R3");
      frame(7'h2A, "R5");
      fork
         play();
         begin
            push_byte(7'h55);
            @(negedge clk);
            chk(tx_ready === 1'b0, "R7", int'(tx_ready), 0);
            push_byte(7'h2A);
            repeat (40 * D) @(posedge clk);
            pulse_brk();
            @(negedge clk);
            chk(tx_busy === 1'b1, "R6", int'(tx_busy), 1);
         end
      join
      quiet = 0;
      repeat (40 * D) begin
         @(negedge clk);
         if (bus_oe) quiet++;
      end
      chk(quiet == 0, "R6", quiet, 0);

      // marker, gap, then a buffered character (R2, R5)
      seg(1'b0, OVS, "R4");
      seg(1'b1, BRK, "R2");
      seg(1'b0, MARK, "R2");
      frame(7'h13, "R5");
      fork
         play();
         begin
            pulse_brk();
            push_byte(7'h13);
            repeat (100 * D) @(posedge clk);
            @(negedge clk);
            chk(tx_busy === 1'b1 && tx_ready === 1'b0, "R6",
                int'({tx_busy, tx_ready}), 2);
         end
      join
      repeat (10) @(negedge clk);
      chk(!tx_busy && tx_ready, "R6", int'({tx_busy, tx_ready}), 1);

      // receive: noise and a character before any marker (R9)
      drive(1'b0, 40);
      drive(1'b1, 100);
      drive(1'b0, 40);
      chk(nbrk == 0, "R9", nbrk, 0);
      send_char(7'h41, 1'b0, 1'b0);
      @(negedge clk);
      chk(gd.size() == 0, "R9", gd.size(), 0);

      // full marker (R8)
      drive(1'b1, 240);
      drive(1'b0, 40);
      @(negedge clk);
      chk(nbrk == 1, "R8", nbrk, 1);

      // start glitch (R11)
      drive(1'b1, 3);
      drive(1'b0, 40);
      @(negedge clk);
      chk(gd.size() == 0, "R11", gd.size(), 0);

      // characters (R10)
      send_char(7'h41, 1'b0, 1'b1);
      send_char(7'h7F, 1'b0, 1'b1);
      send_char(7'h00, 1'b0, 1'b1);
      send_char(7'h35, 1'b1, 1'b1);
      repeat (4 * D) @(negedge clk);
      chk(gd.size() == ed.size(), "R10", gd.size(), ed.size());
      while (ed.size() > 0 && gd.size() > 0) begin
         logic [6:0] xd, ad;
         logic xp, ap;
         xd = ed.pop_front(); xp = ep.pop_front();
         ad = gd.pop_front(); ap = gp.pop_front();
         chk(ad == xd, "R10", int'(ad), int'(xd));
         chk(ap == xp, "R10", int'(ap), int'(xp));
      end

      // wake strobes (R12)
      chk(nwake == rises, "R12", nwake, rises);
      chk(nbrk == 1, "R8", nbrk, 1);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule